// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This peripheral holds a number of identical 32-bit timer channels behind a small register bus. Each channel counts down on a prescaled copy of the bus clock. Software writes a start value into a reload register. It then writes a control word that sets the count enable and the trigger bits. This loads the counter and starts it. When the counter steps past zero, the channel raises a sticky underflow flag. The counter then either restarts from the reload value (periodic mode) or parks at all ones and stops (one-shot mode).

The interrupt line of each channel follows the underflow flag, gated by the interrupt enable. An interrupt handler clears the flag with a read-modify-write that writes 0 to the flag bit. A free-running channel loaded with all ones gives a decreasing time base. Software reads it from the count register.

Top module: `ivt_timer`

## Requirements
- R1: Channel c decodes at byte address 0x10*c. Within a channel the offsets are: 0x0 control, 0x4 count, 0x8 reload value (used for loading), 0xC spare reload value (storage only). Both reload registers read back what was last written. After reset every register reads 0.
- R2: Control bit positions are: 5 output level (plain storage), 4 reload enable, 3 interrupt enable, 2 underflow flag, 1 count enable, 0 trigger. The trigger bit always reads 0.
- R3: A control write with bit 0 set loads the counter from the reload value, and the new count is visible in the next cycle. A trigger with bit 1 clear loads the counter but does not count.
- R4: While bit 1 is set, the counter drops by one every PRESCALE clocks (default 2). The first step comes PRESCALE clocks after the write that started it.
- R5: With bit 4 set, a step taken at count 0 reloads the current reload value and counting continues. A reload value written while the channel runs takes effect at the next underflow.
- R6: With bit 4 clear, a step taken at count 0 sets the counter to all ones and clears bit 1, and the counter then holds.
- R7: Every underflow sets bit 2. A control write with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it as it was.
- R8: irq[c] is high exactly when bits 2 and 3 of channel c are both 1.
- R9: Writing 0 to the control register stops the counter at its present value and drops the interrupt.
- R10: Channels run independently. Activity in one channel never changes the registers of another.
- R11: The count register is read-only. A write to offset 0x4 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWe | input | 1 | Write strobe, one access per high cycle |
| busWdata | input | DW (32) | Write data |
| busRdata | output | DW (32) | Read data, combinational from busAddr |
| irq | output | NUM_CH (2) | Interrupt line per channel |

## Verification
A wrong prescaler or counter state shows up directly in the count register. It appears within a few clocks of a trigger, as a value off by at least one step on a tick boundary. A wrong mode or flag state shows at the control register, and on irq, at the edge where the count crosses zero. The bench samples the count, the control word and irq at computed distances from the start edge, including exact underflow edges. A slip of a single prescaled tick therefore fails a check.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CTRL_W   = 6;
  localparam int BIT_TRIG = 0;
  localparam int BIT_RUN  = 1;
  localparam int BIT_UF   = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_REL  = 4;
  localparam int BIT_LVL  = 5;

  // strobes from channel control to channel datapath
  typedef struct packed {
    logic load;       // copy reload value into counter
    logic tick;       // prescaled count step
    logic useReload;  // periodic wrap target
    logic wrRel1;
    logic wrRel2;
  } ivt_strobe_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              rel1We,
  input  logic              rel2We,
  input  logic              countZero,
  output ivt_strobe_t       stb,
  output logic [CTRL_W-1:0] ctrlRd,
  output logic              irq,
  output logic              tick,
  output logic              cntEn,
  output logic              relEn,
  output logic              irqEn,
  output logic              uf
);
  logic outLvlQ, relEnQ, irqEnQ, ufQ, cntEnQ;
  logic load, ufEvent;

  assign load = ctrlWe & ctrlWdata[BIT_TRIG];

  generate
    if (PRESCALE <= 1) begin : g_noPs
      assign tick = cntEnQ;
    end else begin : g_ps
      localparam int PS_W = $clog2(PRESCALE);
      logic [PS_W-1:0] psQ;
      assign tick = cntEnQ && (psQ == PS_W'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       psQ <= '0;
        else if (!cntEnQ || load || tick) psQ <= '0;
        else                             psQ <= psQ + 1'b1;
      end
    end
  endgenerate

  assign ufEvent = tick & countZero & ~load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLvlQ <= 1'b0;
      relEnQ  <= 1'b0;
      irqEnQ  <= 1'b0;
      ufQ     <= 1'b0;
      cntEnQ  <= 1'b0;
    end else if (ctrlWe) begin
      outLvlQ <= ctrlWdata[BIT_LVL];
      relEnQ  <= ctrlWdata[BIT_REL];
      irqEnQ  <= ctrlWdata[BIT_IE];
      cntEnQ  <= ctrlWdata[BIT_RUN];
      ufQ     <= (ufQ & ctrlWdata[BIT_UF]) | ufEvent;
    end else begin
      ufQ <= ufQ | ufEvent;
      if (ufEvent && !relEnQ) cntEnQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlRd           = '0;
    ctrlRd[BIT_LVL]  = outLvlQ;
    ctrlRd[BIT_REL]  = relEnQ;
    ctrlRd[BIT_IE]   = irqEnQ;
    ctrlRd[BIT_UF]   = ufQ;
    ctrlRd[BIT_RUN]  = cntEnQ;
    ctrlRd[BIT_TRIG] = 1'b0;
  end

  assign stb.load      = load;
  assign stb.tick      = tick;
  assign stb.useReload = relEnQ;
  assign stb.wrRel1    = rel1We;
  assign stb.wrRel2    = rel2We;

  assign irq   = ufQ & irqEnQ;
  assign cntEn = cntEnQ;
  assign relEn = relEnQ;
  assign irqEn = irqEnQ;
  assign uf    = ufQ;
endmodule

// File: rtl/ivt_dpath.sv
module ivt_dpath
  import ivt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ivt_strobe_t   stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic [DW-1:0] rel1,
  output logic [DW-1:0] rel2,
  output logic          countZero
);
  logic [DW-1:0] countQ, rel1Q, rel2Q;

  assign countZero = (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      rel1Q  <= '0;
      rel2Q  <= '0;
    end else begin
      if (stb.wrRel1) rel1Q <= wdata;
      if (stb.wrRel2) rel2Q <= wdata;
      if (stb.load)
        countQ <= rel1Q;
      else if (stb.tick)
        countQ <= countZero ? (stb.useReload ? rel1Q : '1) : countQ - 1'b1;
    end
  end

  assign count = countQ;
  assign rel1  = rel1Q;
  assign rel2  = rel2Q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DW       = 32,
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CH_W = ADDR_W - 4;

  logic [CH_W-1:0] chIdx;
  logic [1:0]      regSel;
  logic            addrUnused;

  assign chIdx      = busAddr[ADDR_W-1:4];
  assign regSel     = busAddr[3:2];
  assign addrUnused = ^busAddr[1:0];

  logic [NUM_CH-1:0][DW-1:0]     chCount, chRel1, chRel2;
  logic [NUM_CH-1:0][CTRL_W-1:0] chCtrl;
  logic [NUM_CH-1:0] chTick, chUf, chCntEn, chRelEn, chIrqEn;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic        hit, zero;
    ivt_strobe_t stb;

    assign hit = busWe && (chIdx == CH_W'(c));

    ivt_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .ctrlWe    (hit && regSel == 2'd0),
      .ctrlWdata (busWdata[CTRL_W-1:0]),
      .rel1We    (hit && regSel == 2'd2),
      .rel2We    (hit && regSel == 2'd3),
      .countZero (zero),
      .stb       (stb),
      .ctrlRd    (chCtrl[c]),
      .irq       (irq[c]),
      .tick      (chTick[c]),
      .cntEn     (chCntEn[c]),
      .relEn     (chRelEn[c]),
      .irqEn     (chIrqEn[c]),
      .uf        (chUf[c])
    );

    ivt_dpath #(.DW(DW)) u_dpath (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb),
      .wdata     (busWdata),
      .count     (chCount[c]),
      .rel1      (chRel1[c]),
      .rel2      (chRel2[c]),
      .countZero (zero)
    );
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chIdx == CH_W'(c)) begin
        case (regSel)
          2'd0:    busRdata = {{(DW-CTRL_W){1'b0}}, chCtrl[c]};
          2'd1:    busRdata = chCount[c];
          2'd2:    busRdata = chRel1[c];
          default: busRdata = chRel2[c];
        endcase
      end
    end
  end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int DW     = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busWe,
  input logic [NUM_CH-1:0]        irq,
  input logic [NUM_CH-1:0][DW-1:0] chCount,
  input logic [NUM_CH-1:0]        chTick,
  input logic [NUM_CH-1:0]        chUf,
  input logic [NUM_CH-1:0]        chCntEn,
  input logic [NUM_CH-1:0]        chRelEn
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |-> chUf[c]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!chCntEn[c] && !busWe) |=> $stable(chCount[c]));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chTick[c] && chCount[c] != '0 && !busWe) |=> chCount[c] == $past(chCount[c]) - DW'(1));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chTick[c] && chCount[c] == '0 && !chRelEn[c] && !busWe) |=> (!chCntEn[c] && (&chCount[c])));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chTick[c] && chCount[c] == '0 && !busWe) |=> chUf[c]);
  end
endmodule

bind ivt_timer ivt_timer_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWe   (busWe),
  .irq     (irq),
  .chCount (chCount),
  .chTick  (chTick),
  .chUf    (chUf),
  .chCntEn (chCntEn),
  .chRelEn (chRelEn)
);

// File: tb/tb_ivt_timer.sv
`timescale 1ns/1ps
module tb_ivt_timer;
  localparam int PS = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWe;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ivt_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write, consumes exactly one rising edge; returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expCount(input logic [31:0] rel, input int e, input bit periodic);
    int t;
    t = e / PS;
    if (periodic) return rel - 32'(t % (int'(rel) + 1));
    if (t <= int'(rel)) return rel - 32'(t);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] expCtrl(input logic [31:0] rel, input int e, input bit periodic, input bit ie);
    int  t;
    bit  f, run;
    t   = e / PS;
    f   = (t >= int'(rel) + 1);
    run = periodic ? 1'b1 : (t <= int'(rel));
    return {26'd0, 1'b0, periodic, ie, f, run, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0;
    void'($urandom(32'd7321));
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) begin
        rd(8'(c * 16 + r * 4), d);
        chk("R1 reset register", d, 32'h0);
      end
    chk("R8 irq after reset", {30'd0, irq}, 32'h0);

    // R1 / R10 reload readback and isolation
    wr(8'h18, 32'hA5A5_0001);
    wr(8'h1C, 32'h5A5A_0002);
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'h8765_4321);
    rd(8'h18, d); chk("R1 ch1 reload", d, 32'hA5A5_0001);
    rd(8'h1C, d); chk("R1 ch1 spare reload", d, 32'h5A5A_0002);
    rd(8'h08, d); chk("R10 ch0 reload", d, 32'h1234_5678);
    rd(8'h0C, d); chk("R1 ch0 spare reload", d, 32'h8765_4321);

    // R11 count is read-only
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, d); chk("R11 count write ignored", d, 32'h0);

    // R2 output level storage
    wr(8'h00, 32'h20);
    rd(8'h00, d); chk("R2 output level bit", d, 32'h20);
    chk("R8 irq low with level bit", {30'd0, irq}, 32'h0);
    wr(8'h00, 32'h0);

    // R3 R5 R7 R8 periodic with interrupt
    wr(8'h08, 32'd3);
    wr(8'h00, 32'h1B);
    rd(8'h04, d); chk("R3 load on trigger", d, 32'd3);
    rd(8'h00, d); chk("R2 trigger reads zero", d, 32'h1A);
    edges(8);
    rd(8'h04, d); chk("R5 periodic reload", d, 32'd3);
    rd(8'h00, d); chk("R7 flag set", d, 32'h1E);
    chk("R8 irq raised", {30'd0, irq}, 32'h1);
    rd(8'h14, d); chk("R10 ch1 count untouched", d, 32'h0);
    wr(8'h00, 32'h1E);
    rd(8'h00, d); chk("R7 write one keeps flag", d, 32'h1E);
    wr(8'h00, 32'h1A);
    rd(8'h00, d); chk("R7 write zero clears flag", d, 32'h1A);
    chk("R8 irq dropped", {30'd0, irq}, 32'h0);

    // R9 stop
    wr(8'h00, 32'h0);
    rd(8'h04, a0);
    edges(6);
    rd(8'h04, d); chk("R9 count held after stop", d, a0);
    chk("R9 irq low after stop", {30'd0, irq}, 32'h0);

    // R5 reload change mid-run
    wr(8'h08, 32'd4);
    wr(8'h00, 32'h13);
    wr(8'h08, 32'd1);
    edges(9);
    rd(8'h04, d); chk("R5 new reload at underflow", d, 32'd1);
    edges(2);
    rd(8'h04, d); chk("R5 count after new reload", d, 32'd0);
    edges(2);
    rd(8'h04, d); chk("R5 second wrap", d, 32'd1);

    // R6 one-shot
    wr(8'h00, 32'h0);
    wr(8'h08, 32'd2);
    wr(8'h00, 32'h03);
    edges(6);
    rd(8'h04, d); chk("R6 one-shot parks at ones", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R6 run bit cleared", d, 32'h04);
    edges(10);
    rd(8'h04, d); chk("R6 holds after stop", d, 32'hFFFF_FFFF);

    // R4 free-running from all ones
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, 32'h13);
    edges(10);
    rd(8'h04, d); chk("R4 decreasing time base", d, 32'hFFFF_FFFA);
    edges(1);
    rd(8'h04, d); chk("R4 prescale holds between ticks", d, 32'hFFFF_FFFA);

    // R3 trigger without enable
    wr(8'h00, 32'h0);
    wr(8'h08, 32'd7);
    wr(8'h00, 32'h01);
    rd(8'h04, d); chk("R3 load without run", d, 32'd7);
    edges(6);
    rd(8'h04, d); chk("R3 no counting without run", d, 32'd7);
    wr(8'h00, 32'h0);

    // constrained random runs, R4 R5 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      int          ch, n;
      logic [31:0] rel;
      bit          per, ie;
      logic [7:0]  base;
      ch   = int'($urandom % 2);
      rel  = 32'($urandom % 12);
      per  = 1'($urandom % 2);
      ie   = 1'($urandom % 2);
      n    = int'($urandom % (4 * (int'(rel) + 1) + 4));
      base = 8'(ch * 16);
      wr(base, 32'h0);
      wr(base + 8'h08, rel);
      wr(base, {27'd0, per, ie, 1'b0, 1'b1, 1'b1});
      edges(n);
      rd(base + 8'h04, d);
      chk(per ? "R5 random periodic count" : "R6 random one-shot count", d, expCount(rel, n, per));
      rd(base, d);
      chk("R7 random control word", d, expCtrl(rel, n, per, ie));
      chk("R8 random irq", {31'd0, irq[ch]},
          {31'd0, ie && ((n / PS) >= int'(rel) + 1)});
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule